// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a physical address by walking a radix page table held in memory. A request carries the virtual address, the kind of access (load, store or fetch), the effective privilege, and two permission modifiers. One allows supervisor code to touch user pages. The other lets loads read execute-only pages. The translation register supplies the scheme selector and the root page number. The walker reads one table entry per level through a memory port with a valid/ready handshake. It checks the leaf entry it finds and, when needed, writes the entry back with its accessed and dirty flags set. It then reports the physical address, the read/write/execute permissions, and a fault flag in a one-cycle completion pulse.

Four radix schemes can be selected. They differ in level count, index width and entry size. Bare mode and machine privilege skip the walk. Only one request is in flight at a time. The caller holds off its next request until `req_ready` returns.

Top module: `ptw_top`

## Requirements
- R1: Scheme code 1 walks 2 levels with 10-bit indices and 4-byte entries. Codes 8, 9 and 10 walk 3, 4 and 5 levels with 9-bit indices and 8-byte entries. Each level reads at base + index × entry size. The first base is the root page number × 4096. Any code other than these and 0 faults with no memory access.
- R2: Scheme code 0 (bare), or privilege 3 (machine), completes in the cycle after acceptance with no memory access. It returns the low 56 address bits unchanged, with read, write and execute all set. Privilege codes are 0 user, 1 supervisor, 3 machine.
- R3: For codes 8/9/10, every virtual address bit above the translated width (12 + levels × 9) must equal the top translated bit. Otherwise the request faults with no memory access. Code 1 uses only the low 32 bits.
- R4: Entry flags sit at bit 0 V, 1 R, 2 W, 3 X, 4 U, 6 A and 7 D. The page number starts at bit 10. An entry with V clear faults. V set with R, W and X clear is a pointer, and its page number × 4096 becomes the next base. A pointer at the last level faults.
- R5: A leaf with W set and R clear (W alone, or W with X) faults.
- R6: A U page faults for a non-user privilege when the user-access modifier is clear or the access is a fetch. A page with U clear faults unless the privilege is supervisor.
- R7: Access code 0 (load) needs R, or X with the execute-readable modifier. Code 1 (store) needs W. Code 2 (fetch) needs X. Code 3 faults.
- R8: A leaf found above the last level faults if the page-number bits it spans are non-zero. Otherwise those bits come from the virtual page number, and the 12-bit offset passes through.
- R9: A successful leaf missing A, or missing D on a store, is written back to the same address with A set (and D set for a store) before completion. No write occurs otherwise.
- R10: Reported read = R or (X and execute-readable). Execute = X. Write = W and (store or D already set). A fault reports address 0 and no permissions.
- R11: An error response on any entry read faults the request.
- R12: `req_ready` is high only when idle. No memory request is issued while idle. A memory request holds its address and direction until accepted. `done_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| req_user_ok | input | 1 | Supervisor may access user pages |
| req_exec_rd | input | 1 | Loads may read execute-only pages |
| xlat_mode | input | 4 | Scheme selector: 0 bare, 1, 8, 9, 10 |
| xlat_root | input | 44 | Root table page number |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write-back, 0 entry read |
| mem_req_dword | output | 1 | 1 for 8-byte, 0 for 4-byte access |
| mem_req_addr | output | 56 | Entry physical address |
| mem_req_wdata | output | 64 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_rdata | input | 64 | Read data (low 32 bits for 4-byte) |
| mem_rsp_err | input | 1 | Read response error |
| done_valid | output | 1 | Result pulse |
| done_paddr | output | 56 | Physical address |
| done_r | output | 1 | Read permitted |
| done_w | output | 1 | Write permitted |
| done_x | output | 1 | Execute permitted |
| done_fault | output | 1 | Translation fault |

## Verification
The checker assumes the memory side answers each accepted read with exactly one response, and never raises a response while no read is pending. It also assumes writes need no response. Its error-to-fault property depends on that pairing. The bench memory model records each read at the handshake and answers it on the next cycle. It completes writes on acceptance and keeps `mem_req_ready` high. Requests are driven only while `req_ready` is high, and each request is held for a single accepting cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W  = 64;
    localparam int PA_W  = 56;
    localparam int OFF_W = 12;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int PTE_W = 64;
    localparam int LVL_W = 3;
    localparam int SH_W  = 6;
    localparam int IDX_MAX_W = 10;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_A = 6;
    localparam int B_D = 7;
    localparam int B_PPN = 10;

    localparam logic [3:0] XM_BARE = 4'd0;
    localparam logic [3:0] XM_N32  = 4'd1;
    localparam logic [3:0] XM_W39  = 4'd8;
    localparam logic [3:0] XM_W48  = 4'd9;
    localparam logic [3:0] XM_W57  = 4'd10;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [1:0] PRV_USER  = 2'd0;
    localparam logic [1:0] PRV_SUPER = 2'd1;
    localparam logic [1:0] PRV_MACH  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_RWAIT, ST_WR, ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic             ok;
        logic [LVL_W-1:0] levels;
        logic [3:0]       idx_w;
        logic             narrow;
    } geom_t;

    typedef struct packed {
        logic [VA_W-1:0] vaddr;
        logic [1:0]      acc;
        logic [1:0]      priv;
        logic            user_ok;
        logic            exec_rd;
        logic [3:0]      mode;
    } walk_req_t;

    typedef struct packed {
        logic             is_ptr;
        logic             fault;
        logic             need_wb;
        logic             r;
        logic             w;
        logic             x;
        logic [PA_W-1:0]  paddr;
        logic [PA_W-1:0]  next_base;
        logic [PTE_W-1:0] wb_pte;
    } leaf_res_t;

    function automatic geom_t geom_of(input logic [3:0] m);
        geom_t g;
        case (m)
            XM_N32:  g = '{1'b1, 3'd2, 4'd10, 1'b1};
            XM_W39:  g = '{1'b1, 3'd3, 4'd9,  1'b0};
            XM_W48:  g = '{1'b1, 3'd4, 4'd9,  1'b0};
            XM_W57:  g = '{1'b1, 3'd5, 4'd9,  1'b0};
            default: g = '{1'b0, 3'd0, 4'd0,  1'b0};
        endcase
        return g;
    endfunction

    // Page-number bits spanned below the given level (0 = root level).
    function automatic logic [SH_W-1:0] lvl_low_bits(input geom_t g, input logic [LVL_W-1:0] lvl);
        logic [SH_W-1:0] rem;
        rem = SH_W'(g.levels) - SH_W'(1) - SH_W'(lvl);
        return SH_W'(rem * SH_W'(g.idx_w));
    endfunction
endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  geom_t           geom,
    output logic            ok
);
    logic unused_bits;
    assign unused_bits = geom.ok;

    always_comb begin
        int top;
        top = OFF_W + int'(geom.levels) * int'(geom.idx_w) - 1;
        ok = 1'b1;
        if (!geom.narrow) begin
            for (int i = 0; i < VA_W; i++) begin
                if (i > top && vaddr[i] != vaddr[top]) ok = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  vaddr,
    input  geom_t            geom,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  addr
);
    logic [SH_W-1:0]      sh;
    logic [IDX_MAX_W-1:0] idx;
    logic                 unused_bits;
    assign unused_bits = geom.ok;

    always_comb begin
        sh  = SH_W'(OFF_W) + lvl_low_bits(geom, lvl);
        idx = IDX_MAX_W'(vaddr >> sh) & (geom.narrow ? 10'h3FF : 10'h1FF);
        addr = base + (geom.narrow ? (PA_W'(idx) << 2) : (PA_W'(idx) << 3));
    end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  geom_t            geom,
    input  logic [LVL_W-1:0] lvl,
    input  walk_req_t        req,
    output leaf_res_t        res
);
    logic [PPN_W-1:0] ppn, low_mask, vpn;
    logic v, r, w, x, u, d;
    logic is_store, is_fetch, rsvd, prv_bad, acc_bad, misalign;
    logic unused_bits;
    assign unused_bits = ^{pte[PTE_W-1:54], pte[9:8], pte[5], req.vaddr[VA_W-1:PA_W], geom.ok};

    always_comb begin
        ppn      = geom.narrow ? PPN_W'(pte[31:B_PPN]) : pte[53:B_PPN];
        v        = pte[B_V];
        r        = pte[B_R];
        w        = pte[B_W];
        x        = pte[B_X];
        u        = pte[B_U];
        d        = pte[B_D];
        low_mask = (PPN_W'(1) << lvl_low_bits(geom, lvl)) - PPN_W'(1);
        vpn      = req.vaddr[PA_W-1:OFF_W];
        is_store = req.acc == ACC_STORE;
        is_fetch = req.acc == ACC_FETCH;
        rsvd     = w && !r;
        prv_bad  = u ? (req.priv != PRV_USER && (!req.user_ok || is_fetch))
                     : (req.priv != PRV_SUPER);
        acc_bad  = (req.acc == ACC_LOAD && !(r || (x && req.exec_rd)))
                 || (is_store && !w) || (is_fetch && !x) || (req.acc == 2'd3);
        misalign = |(ppn & low_mask);

        res.is_ptr    = v && !r && !w && !x;
        res.fault     = !v || (!res.is_ptr && (rsvd || prv_bad || acc_bad || misalign));
        res.wb_pte    = pte | (PTE_W'(1) << B_A) | (is_store ? (PTE_W'(1) << B_D) : '0);
        res.need_wb   = res.wb_pte != pte;
        res.r         = r || (x && req.exec_rd);
        res.w         = w && (is_store || d);
        res.x         = x;
        res.paddr     = {(ppn & ~low_mask) | (vpn & low_mask), req.vaddr[OFF_W-1:0]};
        res.next_base = {ppn, OFF_W'(0)};
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_priv,
    input  logic              req_user_ok,
    input  logic              req_exec_rd,
    input  logic [3:0]        xlat_mode,
    input  logic [PPN_W-1:0]  xlat_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_dword,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_rdata,
    input  logic              mem_rsp_err,
    output logic              done_valid,
    output logic [PA_W-1:0]   done_paddr,
    output logic              done_r,
    output logic              done_w,
    output logic              done_x,
    output logic              done_fault
);
    walk_st_e         st;
    walk_req_t        req_q, req_in;
    logic [PA_W-1:0]  base_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PTE_W-1:0] wb_q, pte;
    geom_t            geom_q, geom_in;
    logic             canon_ok, bypass;
    leaf_res_t        leaf;

    assign req_in  = '{req_vaddr, req_acc, req_priv, req_user_ok, req_exec_rd, xlat_mode};
    assign geom_in = geom_of(xlat_mode);
    assign geom_q  = geom_of(req_q.mode);
    assign bypass  = (xlat_mode == XM_BARE) || (req_priv == PRV_MACH);
    assign pte     = geom_q.narrow ? {32'b0, mem_rsp_rdata[31:0]} : mem_rsp_rdata;

    ptw_canon_chk u_canon (
        .vaddr (req_vaddr),
        .geom  (geom_in),
        .ok    (canon_ok)
    );

    ptw_entry_addr u_eaddr (
        .base  (base_q),
        .vaddr (req_q.vaddr),
        .geom  (geom_q),
        .lvl   (lvl_q),
        .addr  (mem_req_addr)
    );

    ptw_leaf_eval u_leaf (
        .pte   (pte),
        .geom  (geom_q),
        .lvl   (lvl_q),
        .req   (req_q),
        .res   (leaf)
    );

    assign req_ready     = st == ST_IDLE;
    assign mem_req_valid = (st == ST_RD) || (st == ST_WR);
    assign mem_req_write = st == ST_WR;
    assign mem_req_dword = !geom_q.narrow;
    assign mem_req_wdata = wb_q;
    assign done_valid    = st == ST_DONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            req_q      <= '0;
            base_q     <= '0;
            lvl_q      <= '0;
            wb_q       <= '0;
            done_paddr <= '0;
            done_r     <= 1'b0;
            done_w     <= 1'b0;
            done_x     <= 1'b0;
            done_fault <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q  <= req_in;
                        base_q <= {xlat_root, OFF_W'(0)};
                        lvl_q  <= '0;
                        if (bypass) begin
                            done_paddr <= req_vaddr[PA_W-1:0];
                            {done_r, done_w, done_x} <= 3'b111;
                            done_fault <= 1'b0;
                            st <= ST_DONE;
                        end else if (!geom_in.ok || !canon_ok) begin
                            done_paddr <= '0;
                            {done_r, done_w, done_x} <= 3'b000;
                            done_fault <= 1'b1;
                            st <= ST_DONE;
                        end else begin
                            st <= ST_RD;
                        end
                    end
                end
                ST_RD: if (mem_req_ready) st <= ST_RWAIT;
                ST_RWAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_err && leaf.is_ptr
                            && lvl_q != geom_q.levels - LVL_W'(1)) begin
                            base_q <= leaf.next_base;
                            lvl_q  <= lvl_q + LVL_W'(1);
                            st     <= ST_RD;
                        end else if (mem_rsp_err || leaf.is_ptr || leaf.fault) begin
                            done_paddr <= '0;
                            {done_r, done_w, done_x} <= 3'b000;
                            done_fault <= 1'b1;
                            st <= ST_DONE;
                        end else begin
                            done_paddr <= leaf.paddr;
                            {done_r, done_w, done_x} <= {leaf.r, leaf.w, leaf.x};
                            done_fault <= 1'b0;
                            wb_q <= leaf.wb_pte;
                            st <= leaf.need_wb ? ST_WR : ST_DONE;
                        end
                    end
                end
                ST_WR:   if (mem_req_ready) st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic [1:0]        req_priv,
    input logic [3:0]        xlat_mode,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic [PTE_W-1:0]  mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_err,
    input logic              done_valid,
    input logic [PA_W-1:0]   done_paddr,
    input logic              done_r,
    input logic              done_w,
    input logic              done_x,
    input logic              done_fault
);
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    a_r10_fault_clean: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault |-> !done_r && !done_w && !done_x && done_paddr == '0);

    a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (xlat_mode == XM_BARE || req_priv == PRV_MACH)
        |=> done_valid && !done_fault && done_r && done_w && done_x
            && done_paddr == $past(req_vaddr[PA_W-1:0]));

    a_r9_wb_accessed: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> mem_req_wdata[B_A]);

    a_r11_err_faults: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && mem_rsp_err |=> done_valid && done_fault);
endmodule

bind ptw_top ptw_checker i_ptw_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_priv      (req_priv),
    .xlat_mode     (xlat_mode),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .done_valid    (done_valid),
    .done_paddr    (done_paddr),
    .done_r        (done_r),
    .done_w        (done_w),
    .done_x        (done_x),
    .done_fault    (done_fault)
);

// File: tb/test_ptw_top.sv
`timescale 1ns/1ps
module test_ptw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_priv = '0;
    logic        req_user_ok = 1'b0;
    logic        req_exec_rd = 1'b0;
    logic [3:0]  xlat_mode = '0;
    logic [43:0] xlat_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic        mem_req_dword;
    logic [55:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_rdata;
    logic        mem_rsp_err;
    logic        done_valid;
    logic [55:0] done_paddr;
    logic        done_r, done_w, done_x, done_fault;

    always #2.5 clk = ~clk;

    ptw_top i_ptw_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv),
        .req_user_ok(req_user_ok), .req_exec_rd(req_exec_rd),
        .xlat_mode(xlat_mode), .xlat_root(xlat_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_dword(mem_req_dword),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_err(mem_rsp_err), .done_valid(done_valid),
        .done_paddr(done_paddr), .done_r(done_r), .done_w(done_w),
        .done_x(done_x), .done_fault(done_fault)
    );

    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;
    localparam logic [63:0] VA0 = 64'h0000_0000_4020_1ABC;

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [55:0] wr_addr;
    logic [63:0] wr_data;
    logic [55:0] err_addr = '1;
    logic [63:0] mem [logic [55:0]];
    logic        pend = 1'b0;
    logic [55:0] pend_addr;
    logic        pend_dw;
    logic [55:0] o_pa;
    logic        o_f;
    logic [2:0]  o_rwx;

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] fl);
        return {10'b0, ppn, 2'b0, fl};
    endfunction

    function automatic logic [63:0] mrd(input logic [55:0] a, input logic dw);
        logic [63:0] w;
        w = mem.exists(a >> 3) ? mem[a >> 3] : 64'h0;
        if (dw) return w;
        return a[2] ? {32'b0, w[63:32]} : {32'b0, w[31:0]};
    endfunction

    task automatic mwr(input logic [55:0] a, input logic [63:0] d, input logic dw);
        logic [63:0] old;
        old = mem.exists(a >> 3) ? mem[a >> 3] : 64'h0;
        if (dw) mem[a >> 3] = d;
        else if (a[2]) mem[a >> 3] = {d[31:0], old[31:0]};
        else mem[a >> 3] = {old[63:32], d[31:0]};
    endtask

    // memory model: reads answered one cycle after acceptance, writes complete on acceptance
    initial begin
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        mem_rsp_err   = 1'b0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mrd(pend_addr, pend_dw);
                mem_rsp_err   = (pend_addr == err_addr);
                pend = 1'b0;
            end
            if (!rst && mem_req_valid) begin
                if (mem_req_write) begin
                    mwr(mem_req_addr, mem_req_wdata, mem_req_dword);
                    wr_cnt++;
                    wr_addr = mem_req_addr;
                    wr_data = mem_req_wdata;
                end else begin
                    pend = 1'b1;
                    pend_addr = mem_req_addr;
                    pend_dw = mem_req_dword;
                    rd_cnt++;
                end
            end
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] va, input logic [3:0] md, input logic [43:0] root,
                       input logic [1:0] acc, input logic [1:0] prv, input logic uok, input logic xrd);
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        req_vaddr = va; xlat_mode = md; xlat_root = root; req_acc = acc;
        req_priv = prv; req_user_ok = uok; req_exec_rd = xrd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int t = 0;
            while (!done_valid && t < 200) begin
                @(negedge clk);
                t++;
            end
        end
        if (!done_valid) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 completion: actual 0 expected 1");
        end
        o_pa  = done_paddr;
        o_f   = done_fault;
        o_rwx = {done_r, done_w, done_x};
    endtask

    task automatic exp_ok(input string rq, input logic [55:0] pa, input logic [2:0] rwx, input int rds);
        chk(rq, "fault", {63'b0, o_f}, 64'd0);
        chk(rq, "paddr", {8'b0, o_pa}, {8'b0, pa});
        chk(rq, "rwx", {61'b0, o_rwx}, {61'b0, rwx});
        chk(rq, "reads", rd_cnt, rds);
    endtask

    task automatic exp_fault(input string rq, input int rds);
        chk(rq, "fault", {63'b0, o_f}, 64'd1);
        chk(rq, "paddr", {8'b0, o_pa}, 64'd0);
        chk(rq, "rwx", {61'b0, o_rwx}, 64'd0);
        chk(rq, "reads", rd_cnt, rds);
        chk(rq, "writes", wr_cnt, 0);
    endtask

    task automatic set_leaf(input logic [63:0] p);
        mwr(56'h102008, p, 1'b1);
    endtask

    task automatic t_reset;
        chk("R12", "ready after reset", {63'b0, req_ready}, 64'd1);
        chk("R12", "done after reset", {63'b0, done_valid}, 64'd0);
        chk("R12", "memreq after reset", {63'b0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_basic;
        set_leaf(mk(44'h3456, FV|FR|FW|FX|FU|FA|FD));
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd0, 1'b0, 1'b0);
        exp_ok("R1", 56'h3456ABC, 3'b111, 3);
        chk("R9", "no writeback", wr_cnt, 0);
    endtask

    task automatic t_ad;
        set_leaf(mk(44'h3456, FV|FR|FW|FU));
        run(VA0, 4'd8, 44'h100, 2'd1, 2'd0, 1'b0, 1'b0);
        exp_ok("R9", 56'h3456ABC, 3'b110, 3);
        chk("R9", "store wb count", wr_cnt, 1);
        chk("R9", "store wb addr", {8'b0, wr_addr}, 64'h102008);
        chk("R9", "store wb data", wr_data, mk(44'h3456, FV|FR|FW|FU|FA|FD));
        set_leaf(mk(44'h3456, FV|FR|FW|FU));
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd0, 1'b0, 1'b0);
        exp_ok("R10", 56'h3456ABC, 3'b100, 3);
        chk("R9", "load wb data", wr_data, mk(44'h3456, FV|FR|FW|FU|FA));
        chk("R9", "load wb count", wr_cnt, 1);
    endtask

    task automatic t_reserved;
        set_leaf(mk(44'h3456, FV|FW|FU|FA|FD));
        run(VA0, 4'd8, 44'h100, 2'd1, 2'd0, 1'b0, 1'b0);
        exp_fault("R5", 3);
        set_leaf(mk(44'h3456, FV|FW|FX|FU|FA|FD));
        run(VA0, 4'd8, 44'h100, 2'd2, 2'd0, 1'b0, 1'b0);
        exp_fault("R5", 3);
    endtask

    task automatic t_priv;
        set_leaf(mk(44'h3456, FV|FR|FX|FU|FA|FD));
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R6", 3);
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b1, 1'b0);
        exp_ok("R6", 56'h3456ABC, 3'b101, 3);
        run(VA0, 4'd8, 44'h100, 2'd2, 2'd1, 1'b1, 1'b0);
        exp_fault("R6", 3);
        set_leaf(mk(44'h3456, FV|FR|FA|FD));
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd0, 1'b1, 1'b0);
        exp_fault("R6", 3);
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_ok("R6", 56'h3456ABC, 3'b100, 3);
    endtask

    task automatic t_access;
        set_leaf(mk(44'h3456, FV|FX|FA|FD));
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R7", 3);
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b1);
        exp_ok("R7", 56'h3456ABC, 3'b101, 3);
        set_leaf(mk(44'h3456, FV|FR|FA|FD));
        run(VA0, 4'd8, 44'h100, 2'd1, 2'd1, 1'b0, 1'b0);
        exp_fault("R7", 3);
        run(VA0, 4'd8, 44'h100, 2'd2, 2'd1, 1'b0, 1'b0);
        exp_fault("R7", 3);
        run(VA0, 4'd8, 44'h100, 2'd3, 2'd1, 1'b0, 1'b0);
        exp_fault("R7", 3);
    endtask

    task automatic t_invalid;
        set_leaf(64'h0);
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R4", 3);
        set_leaf(mk(44'h500, FV));
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R4", 3);
    endtask

    task automatic t_super;
        mwr(56'h101008, mk(44'h200, FV|FR|FW|FA|FD), 1'b1);
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_ok("R8", 56'h201ABC, 3'b110, 2);
        mwr(56'h101008, mk(44'h201, FV|FR|FW|FA|FD), 1'b1);
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R8", 2);
        mwr(56'h101008, mk(44'h102, FV), 1'b1);
        mwr(56'h100008, mk(44'h40000, FV|FR|FA|FD), 1'b1);
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_ok("R8", 56'h40201ABC, 3'b100, 1);
        mwr(56'h100008, mk(44'h101, FV), 1'b1);
    endtask

    task automatic t_canon;
        set_leaf(mk(44'h3456, FV|FR|FA|FD));
        run(VA0 | (64'd1 << 50), 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R3", 0);
        run(64'h0000_0003_4020_1ABC, 4'd5, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R1", 0);
    endtask

    task automatic t_bypass;
        run(64'h0000_0012_3456_789A, 4'd0, 44'h100, 2'd1, 2'd0, 1'b0, 1'b0);
        exp_ok("R2", 56'h12_3456_789A, 3'b111, 0);
        run(VA0, 4'd8, 44'h100, 2'd2, 2'd3, 1'b0, 1'b0);
        exp_ok("R2", 56'h4020_1ABC, 3'b111, 0);
    endtask

    task automatic t_schemes;
        mwr(56'h200004, {32'b0, 32'((44'h201 << 10) | 44'h1)}, 1'b0);
        mwr(56'h20100C, {32'b0, 32'((44'h1234 << 10) | 44'hCF)}, 1'b0);
        run(64'h0000_0000_0040_3ABC, 4'd1, 44'h200, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_ok("R1", 56'h1234ABC, 3'b111, 2);
        mwr(56'h300008, mk(44'h301, FV), 1'b1);
        mwr(56'h301008, mk(44'h302, FV), 1'b1);
        mwr(56'h302008, mk(44'h303, FV), 1'b1);
        mwr(56'h303008, mk(44'h777, FV|FR|FA), 1'b1);
        run(64'h0000_0080_4020_1ABC, 4'd9, 44'h300, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_ok("R1", 56'h777ABC, 3'b100, 4);
        mwr(56'h400008, mk(44'h401, FV), 1'b1);
        mwr(56'h401008, mk(44'h402, FV), 1'b1);
        mwr(56'h402008, mk(44'h403, FV), 1'b1);
        mwr(56'h403008, mk(44'h404, FV), 1'b1);
        mwr(56'h404008, mk(44'h888, FV|FR|FW|FA|FD), 1'b1);
        run(64'h0001_0080_4020_1ABC, 4'd10, 44'h400, 2'd1, 2'd1, 1'b0, 1'b0);
        exp_ok("R1", 56'h888ABC, 3'b110, 5);
    endtask

    task automatic t_memerr;
        set_leaf(mk(44'h3456, FV|FR|FA|FD));
        err_addr = 56'h102008;
        run(VA0, 4'd8, 44'h100, 2'd0, 2'd1, 1'b0, 1'b0);
        exp_fault("R11", 3);
        err_addr = '1;
    endtask

    initial begin
        mwr(56'h100008, mk(44'h101, FV), 1'b1);
        mwr(56'h101008, mk(44'h102, FV), 1'b1);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ad();
        t_reserved();
        t_priv();
        t_access();
        t_invalid();
        t_super();
        t_canon();
        t_bypass();
        t_schemes();
        t_memerr();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #999000;
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule